// File: doc/BRIEF.md
# Vector Arithmetic Flag Generator

This block watches the result of a four-lane single-precision arithmetic unit and turns each result into condition flags. Every lane is classified as zero, negative, underflowed (denormal) or overflowed. The per-lane indications are packed into a 16-bit MAC flag word. They are also reduced to four summary bits in a status word, which keeps sticky copies of those summary bits.

The result arrives as raw IEEE-754 bit patterns with a valid strobe. Lane x is `res_vec[31:0]`, y is `[63:32]`, z is `[95:64]` and w is `[127:96]`.

Control inputs decide four things:
- whether the operation touches the flags at all;
- whether only one lane is meaningful (single-scalar mode);
- whether overflow detection is active;
- whether the operation is a max/min style operation, which must leave the status word alone.

Top module: `vec_flag_gen`

## Requirements
- R1: MAC bits 3:0 carry per-lane zero flags (value is +0 or -0) and bits 7:4 carry per-lane sign flags (sign bit of the lane). Within every nibble the lane order is reversed: x in bit 3, y in bit 2, z in bit 1, w in bit 0.
- R2: MAC bits 11:8 carry per-lane underflow flags. Such a flag is set when the exponent field is zero and the fraction is non-zero.
- R3: MAC bits 15:12 carry per-lane overflow flags when `ovf_det_en` is 1. A flag is set when the lane magnitude with the sign ignored is at or above 0x7F7FFFFF, which includes infinities and NaNs. With `ovf_det_en` at 0 these bits are 0.
- R4: Outside scalar mode, `wr_mask` bit 3 enables lane x, bit 2 y, bit 1 z and bit 0 w. All flags of a disabled lane are 0.
- R5: In scalar mode, only lane x is classified. Its flags land at bit 3 for `scalar_sel`=0, bit 2 for 1, bit 1 for 2 and bit 0 for 3 of each nibble. `wr_mask` is ignored in this mode.
- R6: Status bit 0 is the OR of the MAC zero flags, bit 1 the OR of the sign flags, bit 2 the OR of the underflow flags and bit 3 the OR of the overflow flags. With `nonsticky_upd`=1 these bits are replaced by the new summary. With `nonsticky_upd`=0 the new summary is ORed into them.
- R7: Status bits 9:6 are sticky copies of bits 3:0. Every update ORs the new summary into them. Status bits 5:4 and 11:10 are always 0.
- R8: With `status_hold`=1 an accepted result updates the MAC word but leaves the whole status word unchanged.
- R9: When `res_valid` or `flag_en` is 0, neither the MAC word nor the status word changes (apart from R10).
- R10: `sticky_clr` zeroes status bits 9:6 on the next edge. A summary accepted in the same cycle is ORed in after the clear.
- R11: Both outputs are 0 after reset and change on the first clock edge after an accepted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result vector valid strobe |
| res_vec | input | 128 | Four IEEE-754 single lanes, x in the low word |
| wr_mask | input | 4 | Lane write mask, bit 3 = x |
| flag_en | input | 1 | Operation updates flags |
| scalar_mode | input | 1 | Single-scalar operation |
| scalar_sel | input | 2 | Target lane in scalar mode, 0 = x |
| ovf_det_en | input | 1 | Enables overflow detection |
| nonsticky_upd | input | 1 | Replace (1) or accumulate (0) summary bits |
| status_hold | input | 1 | Max/min operation: status unchanged |
| sticky_clr | input | 1 | Synchronous clear of sticky bits |
| mac_flags | output | 16 | Per-lane flag word |
| status_flags | output | 12 | Summary and sticky status word |

## Verification
A wrong lane classification or a wrong lane placement shows up in `mac_flags` on the edge after the offending result. A wrong summary reduction shows up in the low status bits at that same edge. A sticky register that loses or gains a bit stays wrong in `status_flags[9:6]` until the next clear, so one bad update is visible at every later sample. Hold, gating and clear faults appear as a word that changes, or fails to change, one cycle after the control input. The bench therefore samples both words after every step.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned ELEM_W   = 32;
  localparam int unsigned KINDS    = 4;
  localparam int unsigned MAC_W    = KINDS * LANES;
  localparam int unsigned STAT_W   = 12;
  localparam int unsigned SUM_LSB  = 0;
  localparam int unsigned STK_LSB  = 6;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic sign;
    logic zero;
  } lane_cls_t;
endpackage

// File: rtl/vfg_lane_cls.sv
module vfg_lane_cls
  import vfg_pkg::*;
#(
  parameter int unsigned EW        = 32,
  parameter int unsigned EXP_W     = 8,
  parameter logic [EW-2:0] OVF_LIM = 31'h7F7FFFFF
) (
  input  logic [EW-1:0] elem,
  input  logic          ovf_en,
  output lane_cls_t     cls
);
  localparam int unsigned FRAC_W = EW - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [EW-2:0]     mag;

  assign exp_f  = elem[EW-2 -: EXP_W];
  assign frac_f = elem[FRAC_W-1:0];
  assign mag    = elem[EW-2:0];

  always_comb begin
    cls.zero = (exp_f == '0) && (frac_f == '0);
    cls.sign = elem[EW-1];
    cls.unf  = (exp_f == '0) && (frac_f != '0);
    cls.ovf  = ovf_en && (mag >= OVF_LIM);
  end
endmodule

// File: rtl/vfg_mac_place.sv
module vfg_mac_place
  import vfg_pkg::*;
#(
  parameter int unsigned NL  = 4,
  parameter int unsigned NK  = 4,
  localparam int unsigned SW = $clog2(NL)
) (
  input  logic [NK-1:0][NL-1:0] kind_by_lane,
  input  logic [NL-1:0]         wr_mask,
  input  logic                  scalar_mode,
  input  logic [SW-1:0]         scalar_sel,
  output logic [NK*NL-1:0]      mac_word
);
  logic [NL-1:0] sel_dec;

  always_comb begin
    sel_dec = '0;
    sel_dec[NL-1-int'(scalar_sel)] = 1'b1;
  end

  for (genvar k = 0; k < NK; k++) begin : g_kind
    for (genvar b = 0; b < NL; b++) begin : g_bit
      logic vec_bit;
      logic scl_bit;
      assign vec_bit = kind_by_lane[k][NL-1-b] & wr_mask[b];
      assign scl_bit = kind_by_lane[k][0] & sel_dec[b];
      assign mac_word[k*NL + b] = scalar_mode ? scl_bit : vec_bit;
    end
  end
endmodule

// File: rtl/vfg_status_upd.sv
module vfg_status_upd
  import vfg_pkg::*;
#(
  parameter int unsigned NK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              replace,
  input  logic              clr_sticky,
  input  logic [NK-1:0]     summary,
  output logic [STAT_W-1:0] status
);
  logic [NK-1:0] sum_q, sum_d;
  logic [NK-1:0] stk_q, stk_d;
  logic          sum_en, stk_en;

  always_comb begin
    sum_en = upd;
    stk_en = upd | clr_sticky;
    sum_d  = replace ? summary : (sum_q | summary);
    stk_d  = (clr_sticky ? '0 : stk_q) | (upd ? summary : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      stk_q <= '0;
    end else begin
      if (sum_en) sum_q <= sum_d;
      if (stk_en) stk_q <= stk_d;
    end
  end

  always_comb begin
    status = '0;
    status[SUM_LSB +: NK] = sum_q;
    status[STK_LSB +: NK] = stk_q;
  end
endmodule

// File: rtl/vec_flag_gen.sv
module vec_flag_gen
  import vfg_pkg::*;
#(
  parameter int unsigned NL        = LANES,
  parameter int unsigned EW        = ELEM_W,
  parameter int unsigned EXP_W     = 8,
  parameter logic [EW-2:0] OVF_LIM = 31'h7F7FFFFF,
  localparam int unsigned VW       = NL * EW,
  localparam int unsigned MW       = KINDS * NL,
  localparam int unsigned SW       = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [VW-1:0]     res_vec,
  input  logic [NL-1:0]     wr_mask,
  input  logic              flag_en,
  input  logic              scalar_mode,
  input  logic [SW-1:0]     scalar_sel,
  input  logic              ovf_det_en,
  input  logic              nonsticky_upd,
  input  logic              status_hold,
  input  logic              sticky_clr,
  output logic [MW-1:0]     mac_flags,
  output logic [STAT_W-1:0] status_flags
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [KINDS-1:0][NL-1:0] kind_by_lane;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    lane_cls_t cls;
    vfg_lane_cls #(.EW(EW), .EXP_W(EXP_W), .OVF_LIM(OVF_LIM)) u_cls (
      .elem   (res_vec[l*EW +: EW]),
      .ovf_en (ovf_det_en),
      .cls    (cls)
    );
    assign kind_by_lane[0][l] = cls.zero;
    assign kind_by_lane[1][l] = cls.sign;
    assign kind_by_lane[2][l] = cls.unf;
    assign kind_by_lane[3][l] = cls.ovf;
  end

  logic [MW-1:0] mac_d, mac_q;
  logic          accept, mac_en;

  vfg_mac_place #(.NL(NL), .NK(KINDS)) u_place (
    .kind_by_lane (kind_by_lane),
    .wr_mask      (wr_mask),
    .scalar_mode  (scalar_mode),
    .scalar_sel   (scalar_sel),
    .mac_word     (mac_d)
  );

  logic [KINDS-1:0] summary;
  for (genvar k = 0; k < KINDS; k++) begin : g_sum
    assign summary[k] = |mac_d[k*NL +: NL];
  end

  always_comb begin
    accept = res_valid & flag_en;
    mac_en = accept;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  mac_q <= '0;
    else if (mac_en) mac_q <= mac_d;
  end
  assign mac_flags = mac_q;

  vfg_status_upd #(.NK(KINDS)) u_stat (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .upd        (accept & ~status_hold),
    .replace    (nonsticky_upd),
    .clr_sticky (sticky_clr),
    .summary    (summary),
    .status     (status_flags)
  );
endmodule

// File: rtl/vfg_chk.sv
module vfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        res_valid,
  input logic        flag_en,
  input logic        scalar_mode,
  input logic        ovf_det_en,
  input logic        status_hold,
  input logic        sticky_clr,
  input logic [15:0] mac_flags,
  input logic [11:0] status_flags
);
  p_ovf_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_en && !ovf_det_en) |=> (mac_flags[15:12] == 4'h0));

  p_scalar_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_en && scalar_mode) |=>
      ($onehot0(mac_flags[3:0]) && $onehot0(mac_flags[7:4]) &&
       $onehot0(mac_flags[11:8]) && $onehot0(mac_flags[15:12])));

  p_sticky_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr |=> ((status_flags[9:6] & $past(status_flags[9:6])) == $past(status_flags[9:6])));

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flags[5:4] == 2'b00) && (status_flags[11:10] == 2'b00));

  p_hold_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_en && status_hold && !sticky_clr) |=> $stable(status_flags));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(res_valid && flag_en) && !sticky_clr) |=> ($stable(status_flags) && $stable(mac_flags)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !(res_valid && flag_en)) |=> (status_flags[9:6] == 4'h0));
endmodule

bind vec_flag_gen vfg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid    (res_valid),
  .flag_en      (flag_en),
  .scalar_mode  (scalar_mode),
  .ovf_det_en   (ovf_det_en),
  .status_hold  (status_hold),
  .sticky_clr   (sticky_clr),
  .mac_flags    (mac_flags),
  .status_flags (status_flags)
);

// File: tb/vec_flag_gen_tb_top.sv
module vec_flag_gen_tb_top;
  localparam logic [31:0] P1 = 32'h3F800000, N1 = 32'hBF800000;
  localparam logic [31:0] ZP = 32'h00000000, ZN = 32'h80000000;
  localparam logic [31:0] DN = 32'h00000001, DNN = 32'h80000010;
  localparam logic [31:0] MX = 32'h7F7FFFFF, NMX = 32'hFF7FFFFF;
  localparam logic [31:0] INF = 32'h7F800000, BIG = 32'h7F7FFFFE;

  typedef struct packed {
    logic [127:0] v;
    logic [3:0]   m;
    logic         sc;
    logic [1:0]   sel;
    logic         ov;
    logic [15:0]  exp;
  } vec_t;

  // lanes packed {w,z,y,x}
  localparam vec_t TBL [9] = '{
    '{{ZN, ZP, N1, P1},   4'hF, 1'b0, 2'd0, 1'b1, 16'h0053}, // R1
    '{{BIG, MX, DNN, DN}, 4'hF, 1'b0, 2'd0, 1'b1, 16'h2C40}, // R2 R3
    '{{BIG, MX, DNN, DN}, 4'hF, 1'b0, 2'd0, 1'b0, 16'h0C40}, // R3 off
    '{{BIG, MX, DNN, DN}, 4'h5, 1'b0, 2'd0, 1'b1, 16'h0440}, // R4
    '{{P1, ZN, INF, NMX}, 4'hF, 1'b0, 2'd0, 1'b1, 16'hC0A2}, // R1 R3
    '{{INF, DN, ZP, ZN},  4'h0, 1'b1, 2'd2, 1'b1, 16'h0022}, // R5
    '{{P1, P1, P1, NMX},  4'h1, 1'b1, 2'd0, 1'b1, 16'h8080}, // R5
    '{{ZP, ZP, ZP, DN},   4'hF, 1'b1, 2'd3, 1'b1, 16'h0100}, // R5
    '{{ZN, ZP, N1, P1},   4'h0, 1'b0, 2'd0, 1'b1, 16'h0000}  // R4
  };

  logic clk = 1'b0;
  logic rst_n;
  logic res_valid, flag_en, scalar_mode, ovf_det_en, nonsticky_upd, status_hold, sticky_clr;
  logic [127:0] res_vec;
  logic [3:0] wr_mask;
  logic [1:0] scalar_sel;
  logic [15:0] mac_flags;
  logic [11:0] status_flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_sum, m_stk;

  always #4 clk = ~clk;

  vec_flag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_vec(res_vec),
    .wr_mask(wr_mask), .flag_en(flag_en), .scalar_mode(scalar_mode),
    .scalar_sel(scalar_sel), .ovf_det_en(ovf_det_en), .nonsticky_upd(nonsticky_upd),
    .status_hold(status_hold), .sticky_clr(sticky_clr),
    .mac_flags(mac_flags), .status_flags(status_flags)
  );

  function automatic logic [3:0] summ(input logic [15:0] m);
    return {|m[15:12], |m[11:8], |m[7:4], |m[3:0]};
  endfunction

  function automatic logic [11:0] stat_of(input logic [3:0] s, input logic [3:0] k);
    return {2'b00, k, 2'b00, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [127:0] v, input logic [3:0] m, input logic sc,
                      input logic [1:0] sel, input logic ov, input logic ns,
                      input logic hold, input logic en, input logic vld, input logic clr);
    res_vec = v; wr_mask = m; scalar_mode = sc; scalar_sel = sel; ovf_det_en = ov;
    nonsticky_upd = ns; status_hold = hold; flag_en = en; res_valid = vld; sticky_clr = clr;
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0; sticky_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; res_valid = 0; flag_en = 0; scalar_mode = 0; ovf_det_en = 0;
    nonsticky_upd = 0; status_hold = 0; sticky_clr = 0; res_vec = '0; wr_mask = '0; scalar_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset mac", 32'(mac_flags), 32'h0);
    chk("R11 reset status", 32'(status_flags), 32'h0);

    m_sum = '0; m_stk = '0;
    for (int i = 0; i < 9; i++) begin
      step(TBL[i].v, TBL[i].m, TBL[i].sc, TBL[i].sel, TBL[i].ov, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      m_sum = summ(TBL[i].exp);
      m_stk = m_stk | m_sum;
      chk($sformatf("R1-table %0d mac", i), 32'(mac_flags), 32'(TBL[i].exp));
      chk($sformatf("R6 R7 table %0d status", i), 32'(status_flags), 32'(stat_of(m_sum, m_stk)));
    end

    // R11: output unchanged before the edge, updated after it
    res_vec = {ZN, ZP, N1, P1}; wr_mask = 4'hF; scalar_mode = 0; ovf_det_en = 1;
    nonsticky_upd = 1; status_hold = 0; flag_en = 1; res_valid = 1;
    #1;
    chk("R11 before edge", 32'(mac_flags), 32'h0000);
    @(posedge clk); @(negedge clk); res_valid = 0;
    chk("R11 after edge", 32'(mac_flags), 32'h0053);
    m_sum = 4'b0011;
    m_stk = m_stk | m_sum;

    // R6 accumulate: underflow-only result ORed into summary
    step({ZP, ZP, ZP, DN}, 4'h8, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 accumulate", 32'(status_flags), 32'(stat_of(4'b0111, m_stk)));
    m_sum = 4'b0111;

    // R6 replace
    step({ZP, ZP, ZP, P1}, 4'h8, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 replace", 32'(status_flags), 32'(stat_of(4'b0000, m_stk)));
    m_sum = 4'b0000;

    // R8 max/min hold: mac updates, status frozen
    step({ZP, ZP, ZP, NMX}, 4'h8, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R8 mac updates", 32'(mac_flags), 32'h8080);
    chk("R8 status held", 32'(status_flags), 32'(stat_of(m_sum, m_stk)));

    // R9 flag_en low and valid low change nothing
    step({ZN, ZN, ZN, ZN}, 4'hF, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 flag_en low mac", 32'(mac_flags), 32'h8080);
    chk("R9 flag_en low status", 32'(status_flags), 32'(stat_of(m_sum, m_stk)));
    step({ZN, ZN, ZN, ZN}, 4'hF, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 valid low mac", 32'(mac_flags), 32'h8080);

    // R10 clear alone
    step('0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    m_stk = '0;
    chk("R10 clear sticky", 32'(status_flags), 32'(stat_of(m_sum, 4'h0)));

    // R10 clear with same-cycle update: new summary survives
    step({ZP, ZP, ZP, ZP}, 4'h8, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R10 clear plus update", 32'(status_flags), 32'(stat_of(4'b0001, 4'b0001)));

    // R3 boundary: just below limit is not overflow, max finite is
    step({ZP, ZP, ZP, BIG}, 4'h8, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 below limit", 32'(mac_flags), 32'h0000);
    step({ZP, ZP, ZP, MX}, 4'h8, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 at limit", 32'(mac_flags), 32'h8000);
    chk("R3 overflow status", 32'(status_flags), 32'(stat_of(4'b1000, 4'b1001)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule